// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a peripheral has left stuck, for example after a reset in the middle of a read. It is started by a one-cycle command strobe. At that moment it looks at the sampled levels of SDA and SCL and picks one of three courses.

If both lines are high, the bus is already free and the block reports completion at once. If SDA is held low, the block clocks SCL up to a parameterised number of times, eight by default. After each pulse it checks SDA, and it stops as soon as the target lets go of the line. It then places a clean STOP condition on the bus. If SDA is high but SCL is held low, it skips the clock pulses and goes straight to the STOP sequence.

Both lines are driven open-drain. An output high means "pull the line low", and the block never drives a line high. Phase lengths are counted in ticks from a shared timing generator and come from two length inputs. Completion is a one-cycle done pulse, with a fail flag alongside it when the bus could not be freed.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset neither line is pulled low, and busy_o, done_o and fail_o are all 0.
- R2: A start with SDA and SCL both high gives done_o=1 with fail_o=0 in the cycle after the strobe. No line is driven.
- R3: A start with SDA low produces SCL pulses until SDA reads high. A target that releases after its Nth pulse (N from 1 to 8) sees exactly N pulses.
- R4: Each recovery pulse holds SCL low for low_len_i ticks and then releases it for high_len_i ticks. A length of 0 acts as 1. With tick_i held at 1, one tick equals one clock.
- R5: SDA is sampled only at the end of each released-SCL phase. The pulse train stops at the first sample that reads SDA high.
- R6: After SDA is freed, a STOP is generated in this order: SCL is pulled low, then SDA is pulled low while SCL stays low, then SCL is released, then SDA is released while SCL is high. SDA is never pulled low while SCL is released.
- R7: If SDA still reads low at the end of the final pulse, done_o and fail_o rise together and no STOP is attempted.
- R8: A start with SDA high and SCL low runs only the STOP sequence, with no recovery pulses. fail_o is set with done_o if either line reads low when the STOP sequence ends.
- R9: done_o and fail_o last one cycle. busy_o is 1 from the cycle after an accepted start until done_o rises, and it is 0 while done_o is 1.
- R10: A start strobe while busy_o is 1 is ignored. The run in progress is neither restarted nor lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle recovery command |
| tick_i | input | 1 | Phase-timing tick from the timing generator |
| low_len_i | input | LEN_W | SCL low phase length in ticks |
| high_len_i | input | LEN_W | SCL high phase length in ticks |
| scl_in_i | input | 1 | Sampled SCL level |
| sda_in_i | input | 1 | Sampled SDA level |
| scl_drive_low_o | output | 1 | 1 pulls SCL low |
| sda_drive_low_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | With done_o: bus still held |

## Verification
A wrong pulse count or a wrong sampling point is visible on the bus model as an extra pulse or a missing pulse. It shows within one phase of where the target releases SDA. An error in STOP ordering shows either as a START-like SDA fall while SCL is high, or as no STOP edge before done_o. A mix-up in the stuck-line cases shows as done_o arriving with the wrong fail_o value, or as pulses on a bus that needed none. A corrupted phase timer shows as a low or high phase whose length in cycles differs from the programmed count, starting with the very first pulse.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLO,
        ST_PHI,
        ST_SCLK,
        ST_SSET,
        ST_SHI,
        ST_SREL
    } ust_state_e;
endpackage

// File: rtl/unstick_phase_timer.sv
module unstick_phase_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             expire_o
);
    logic [LEN_W-1:0] cnt_d, cnt_q;
    logic [LEN_W-1:0] last;

    always_comb begin
        last     = (len_i == '0) ? '0 : len_i - LEN_W'(1);
        expire_o = tick_i && !restart_i && (cnt_q >= last);
        cnt_d    = cnt_q;
        if (restart_i || expire_o) cnt_d = '0;
        else if (tick_i)           cnt_d = cnt_q + LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
    import unstick_pkg::*;
#(
    parameter int MAX_PULSES = 8,
    parameter int LEN_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sda_in_i,
    input  logic             scl_in_i,
    input  logic             expire_i,
    input  logic [LEN_W-1:0] low_len_i,
    input  logic [LEN_W-1:0] high_len_i,
    output logic [LEN_W-1:0] len_o,
    output logic             restart_o,
    output logic             scl_low_o,
    output logic             sda_low_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o
);
    localparam int PC_W = $clog2(MAX_PULSES + 1);

    typedef struct packed {
        ust_state_e      state;
        logic [PC_W-1:0] pulses;
        logic            done;
        logic            fail;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        unique case (r_q.state)
            ST_IDLE: if (start_i) begin
                r_d.pulses = '0;
                if (sda_in_i && scl_in_i) r_d.done  = 1'b1;
                else if (!sda_in_i)       r_d.state = ST_PLO;
                else                      r_d.state = ST_SCLK;
            end
            ST_PLO: if (expire_i) begin
                r_d.state  = ST_PHI;
                r_d.pulses = r_q.pulses + PC_W'(1);
            end
            ST_PHI: if (expire_i) begin
                if (sda_in_i) r_d.state = ST_SCLK;
                else if (r_q.pulses == PC_W'(MAX_PULSES)) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.fail  = 1'b1;
                end else r_d.state = ST_PLO;
            end
            ST_SCLK: if (expire_i) r_d.state = ST_SSET;
            ST_SSET: if (expire_i) r_d.state = ST_SHI;
            ST_SHI:  if (expire_i) r_d.state = ST_SREL;
            ST_SREL: if (expire_i) begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.fail  = !(sda_in_i && scl_in_i);
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, pulses: '0, done: 1'b0, fail: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        restart_o = (r_q.state == ST_IDLE);
        len_o     = (r_q.state inside {ST_PLO, ST_SCLK, ST_SSET}) ? low_len_i : high_len_i;
        scl_low_o = r_q.state inside {ST_PLO, ST_SCLK, ST_SSET};
        sda_low_o = r_q.state inside {ST_SSET, ST_SHI};
        busy_o    = (r_q.state != ST_IDLE);
        done_o    = r_q.done;
        fail_o    = r_q.fail;
    end

    AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && sda_in_i && scl_in_i) |=> (done_o && !fail_o)); // R2
    AST_NO_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_o) |-> scl_low_o); // R6
    AST_STOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_low_o) |-> !scl_low_o); // R6
    AST_GIVE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PHI && expire_i && !sda_in_i && r_q.pulses == PC_W'(MAX_PULSES))
        |=> (done_o && fail_o)); // R7
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !expire_i) |=> busy_o); // R10
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
    parameter int MAX_PULSES = 8,
    parameter int LEN_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [LEN_W-1:0] low_len_i,
    input  logic [LEN_W-1:0] high_len_i,
    input  logic             scl_in_i,
    input  logic             sda_in_i,
    output logic             scl_drive_low_o,
    output logic             sda_drive_low_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o
);
    logic             restart;
    logic             expire;
    logic [LEN_W-1:0] len;

    unstick_phase_timer #(.LEN_W(LEN_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .tick_i    (tick_i),
        .len_i     (len),
        .expire_o  (expire)
    );

    unstick_fsm #(.MAX_PULSES(MAX_PULSES), .LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .sda_in_i   (sda_in_i),
        .scl_in_i   (scl_in_i),
        .expire_i   (expire),
        .low_len_i  (low_len_i),
        .high_len_i (high_len_i),
        .len_o      (len),
        .restart_o  (restart),
        .scl_low_o  (scl_drive_low_o),
        .sda_low_o  (sda_drive_low_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .fail_o     (fail_o)
    );
endmodule

// File: tb/i2c_bus_unstick_bench.sv
module i2c_bus_unstick_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] low_len = 8'd2;
    logic [7:0] high_len = 8'd2;
    logic       scl_drv, sda_drv, busy, done, fail;
    logic       hold = 1'b0;
    logic       scl_stuck = 1'b0;
    logic       scl_in, sda_in;
    int         tick_div = 1;
    int         tcnt = 0;
    int         total = 0;
    int         bad = 0;

    always #2 clk = ~clk;

    assign sda_in = !(sda_drv || hold);
    assign scl_in = !(scl_drv || scl_stuck);

    always @(negedge clk) begin
        tcnt = (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
        tick = (tcnt == 0);
    end

    i2c_bus_unstick u_i2c_bus_unstick (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
        .low_len_i(low_len), .high_len_i(high_len),
        .scl_in_i(scl_in), .sda_in_i(sda_in),
        .scl_drive_low_o(scl_drv), .sda_drive_low_o(sda_drv),
        .busy_o(busy), .done_o(done), .fail_o(fail)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode: 0 SCL free, 1 SCL stuck for good, 2 SCL stuck until SDA is pulled
    // rel: target frees SDA after this many pulses (0 = already free, 15 = never)
    task automatic run(input int mode, input int rel, input bit again,
                       output int np, output int f, output int st,
                       output int cyc, output int lo1, output int hi1);
        bit psc = 1'b0;
        bit psd = 1'b1;
        bit fin = 1'b0;
        np = 0; f = 0; st = 0; lo1 = 0; hi1 = 0;
        scl_stuck = (mode != 0);
        hold = (rel != 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; cyc = 1;
        while (!fin && cyc < 3000) begin
            if (done) begin
                fin = 1'b1;
                f = fail;
                check("R9 busy low at done", busy, 0);
            end else begin
                if (scl_drv && !sda_drv && np == 0) lo1++;
                if (psc && !scl_drv && !sda_drv) begin
                    np++;
                    if (np == rel) hold = 1'b0;
                end
                if (np == 1 && !scl_drv) hi1++;
                if (!psd && sda_in && scl_in) st = 1;
                if (mode == 2 && sda_drv) scl_stuck = 1'b0;
                start = (again && cyc == 10);
                psc = scl_drv; psd = sda_in; cyc++;
                @(negedge clk);
            end
        end
        start = 1'b0;
        if (!fin) check("watchdog run", 0, 1);
        @(negedge clk);
        check("R9 done one cycle", done, 0);
        scl_stuck = 1'b0; hold = 1'b0;
    endtask

    // {mode[1:0], rel[3:0], pulses[3:0], fail, stop}
    localparam logic [11:0] VEC [7] = '{
        {2'd0, 4'd0,  4'd0, 1'b0, 1'b0},
        {2'd0, 4'd1,  4'd1, 1'b0, 1'b1},
        {2'd0, 4'd3,  4'd3, 1'b0, 1'b1},
        {2'd0, 4'd8,  4'd8, 1'b0, 1'b1},
        {2'd0, 4'd15, 4'd8, 1'b1, 1'b0},
        {2'd1, 4'd0,  4'd0, 1'b1, 1'b0},
        {2'd2, 4'd0,  4'd0, 1'b0, 1'b1}
    };

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int np, f, st, cyc, lo1, hi1;
        repeat (3) @(negedge clk);
        check("R1 scl drive", scl_drv, 0);
        check("R1 sda drive", sda_drv, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 fail", fail, 0);
        rst_n = 1'b1;
        @(negedge clk);

        tick_div = 2;
        foreach (VEC[i]) begin
            run(int'(VEC[i][11:10]), int'(VEC[i][9:6]), 1'b0, np, f, st, cyc, lo1, hi1);
            check($sformatf("R3 R5 pulses row %0d", i), np, int'(VEC[i][5:2]));
            check($sformatf("R7 R8 fail row %0d", i), f, int'(VEC[i][1]));
            check($sformatf("R6 stop row %0d", i), st, int'(VEC[i][0]));
            if (i == 0) check("R2 done next cycle", cyc, 1);
            repeat (3) @(negedge clk);
        end

        tick_div = 1; low_len = 8'd3; high_len = 8'd5;
        run(0, 2, 1'b0, np, f, st, cyc, lo1, hi1);
        check("R4 low phase cycles", lo1, 3);
        check("R4 high phase cycles", hi1, 5);
        check("R4 pulses", np, 2);

        low_len = 8'd0; high_len = 8'd0;
        run(0, 2, 1'b0, np, f, st, cyc, lo1, hi1);
        check("R4 zero low as one", lo1, 1);
        check("R4 zero high as one", hi1, 1);

        low_len = 8'd2; high_len = 8'd2;
        run(0, 3, 1'b1, np, f, st, cyc, lo1, hi1);
        check("R10 pulses with restart", np, 3);
        check("R10 fail", f, 0);
        repeat (20) @(negedge clk);
        check("R10 no second run", busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule